// File: doc/BRIEF.md
# Converter Interrupt Vector Generator

This block collects the interrupt conditions of a multi-slot data converter and presents them to a processor as one prioritized vector and one request line. There are three kinds of condition. The first is a per-slot result flag, set whenever the sequencer stores a result into that slot. The second is a hidden overwrite overflow, raised when a slot receives a new result before its previous one was read. The third is a hidden timing overflow, raised when a new sample-and-convert request arrives while a conversion is still running. Every condition has its own enable. Only enabled, pending conditions reach the vector and the request line.

Software reads the vector to find the most urgent enabled condition. The value is an even offset that suits a jump table. Reading or writing the vector clears a hidden overflow condition, but only when that condition is the one the vector reports. Slot flags never clear on a vector access. A slot flag clears when its result word is read, or when software writes the flag register. The number of slots is a parameter. Slot enables and the two overflow enables share one enable register.

Top module: `conv_irq_vector`

## Requirements
- R1: The vector reads 0 when no enabled condition is pending, 2 for the overwrite overflow, 4 for the timing overflow and 6 + 2·n for slot flag n. All bits above the vector value read as zero.
- R2: When several enabled conditions are pending, the vector reports the highest of them. The order from highest to lowest is: overwrite overflow, timing overflow, slot 0, slot 1, up to the last slot.
- R3: A condition whose enable bit is 0 has no effect on the vector or on `irq`, but its slot flag still reads back as set in the flag register.
- R4: A vector access (bus read or bus write with select code 2) clears the overwrite or timing overflow only when that condition is the one the vector reports in that cycle. A hidden condition that is pending but not reported stays pending.
- R5: A vector access never changes any slot flag. A `res_rd` strobe on slot n clears flag n. A bus write with select code 0 loads the flag register with the written data, bit n for slot n.
- R6: A `slot_set` strobe on slot n sets flag n in the next cycle. It takes precedence over a result read or a flag-register write in the same cycle.
- R7: The overwrite overflow is raised when `slot_set` hits a slot that has been stored but not read through `res_rd` since then. A set and a read of the same slot in the same cycle raise nothing.
- R8: The timing overflow is raised when `conv_req` is high in a cycle where `conv_busy` is high. A request while the converter is idle raises nothing.
- R9: `irq` is high exactly when at least one enabled condition is pending, so it stays high after one condition is serviced while others remain.
- R10: Select code 1 accesses the enable register: bits NSLOT-1..0 enable the slots, bit NSLOT enables the overwrite overflow and bit NSLOT+1 enables the timing overflow. Select code 0 reads the flags with the upper two bits zero. Select code 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_set | input | NSLOT | One-cycle strobes: a result was stored in slot n |
| res_rd | input | NSLOT | One-cycle strobes: the result word of slot n was read |
| conv_req | input | 1 | Sample-and-convert request strobe |
| conv_busy | input | 1 | A conversion is in progress |
| bus_sel | input | 2 | Register select: 0 flags, 1 enables, 2 vector, 3 none |
| bus_rd | input | 1 | Read strobe for the selected register |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | NSLOT+2 | Write data |
| bus_rdata | output | NSLOT+2 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default of 16 slots, so the vector spans its full range up to 0x024 and both ends of the priority chain (slot 0 and slot 15) can be reached. Directed scenarios stack hidden and visible conditions under different enable masks. They check that an access peels off exactly one hidden condition, and only when that condition is on top. They also cover overflow on a repeated store, with a same-cycle read as the case that must not count.

// File: rtl/conv_irq_pkg.sv
package conv_irq_pkg;

    typedef enum logic [1:0] {
        SEL_FLAGS  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Source indices in priority order, lowest index wins
    localparam int SRC_OVF   = 0;
    localparam int SRC_TOV   = 1;
    localparam int SRC_SLOT0 = 2;

endpackage

// File: rtl/conv_irq_slot_bank.sv
module conv_irq_slot_bank #(
    parameter int NSLOT = 16
) (
    input  logic [NSLOT-1:0] flags_q,
    input  logic [NSLOT-1:0] unread_q,
    input  logic [NSLOT-1:0] slot_set,
    input  logic [NSLOT-1:0] res_rd,
    input  logic             flag_wr,
    input  logic [NSLOT-1:0] flag_wdata,
    output logic [NSLOT-1:0] flags_d,
    output logic [NSLOT-1:0] unread_d,
    output logic             ovf_hit
);

    logic [NSLOT-1:0] hit;

    for (genvar n = 0; n < NSLOT; n++) begin : g_slot
        always_comb begin
            logic base;
            base        = flag_wr ? flag_wdata[n] : flags_q[n];
            flags_d[n]  = (base & ~res_rd[n]) | slot_set[n];
            unread_d[n] = (unread_q[n] & ~res_rd[n]) | slot_set[n];
            hit[n]      = slot_set[n] & unread_q[n] & ~res_rd[n];
        end
    end

    assign ovf_hit = |hit;

endmodule

// File: rtl/conv_irq_prio_enc.sv
module conv_irq_prio_enc #(
    parameter int NSRC = 18,
    parameter int VW   = 6,
    localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] pend,
    output logic            any,
    output logic [IW-1:0]   top_idx,
    output logic [VW-1:0]   vec
);

    always_comb begin
        any     = 1'b0;
        top_idx = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (pend[k]) begin
                any     = 1'b1;
                top_idx = IW'(k);
            end
        end
        vec = any ? VW'(2 * (32'(top_idx) + 1)) : '0;
    end

endmodule

// File: rtl/conv_irq_vector.sv
module conv_irq_vector
    import conv_irq_pkg::*;
#(
    parameter int  NSLOT = 16,
    localparam int DW    = NSLOT + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] slot_set,
    input  logic [NSLOT-1:0] res_rd,
    input  logic             conv_req,
    input  logic             conv_busy,
    input  logic [1:0]       bus_sel,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq
);

    localparam int NSRC = NSLOT + 2;
    localparam int VW   = $clog2(2 * NSRC + 1);
    localparam int IW   = $clog2(NSRC);

    typedef struct packed {
        logic [NSLOT-1:0] flags;
        logic [NSLOT-1:0] unread;
        logic             ovf;
        logic             tov;
        logic [DW-1:0]    en;
    } state_t;

    state_t st_d, st_q;

    logic [NSLOT-1:0] flags_q, flags_nx, unread_nx;
    logic             ovf_q, tov_q, ovf_hit;
    logic [DW-1:0]    en_q;
    logic [NSRC-1:0]  pend;
    logic             any;
    logic [IW-1:0]    top_idx;
    logic [VW-1:0]    vec;
    logic             vec_acc, flag_wr, en_wr;

    assign flags_q = st_q.flags;
    assign ovf_q   = st_q.ovf;
    assign tov_q   = st_q.tov;
    assign en_q    = st_q.en;

    assign vec_acc = (bus_rd | bus_wr) && (bus_sel == SEL_VECTOR);
    assign flag_wr = bus_wr && (bus_sel == SEL_FLAGS);
    assign en_wr   = bus_wr && (bus_sel == SEL_ENABLE);

    // Enabled pending sources, index 0 is highest priority
    assign pend = {st_q.flags & st_q.en[NSLOT-1:0],
                   st_q.tov & st_q.en[NSLOT+1],
                   st_q.ovf & st_q.en[NSLOT]};

    conv_irq_slot_bank #(.NSLOT(NSLOT)) u_bank (
        .flags_q    (st_q.flags),
        .unread_q   (st_q.unread),
        .slot_set   (slot_set),
        .res_rd     (res_rd),
        .flag_wr    (flag_wr),
        .flag_wdata (bus_wdata[NSLOT-1:0]),
        .flags_d    (flags_nx),
        .unread_d   (unread_nx),
        .ovf_hit    (ovf_hit)
    );

    conv_irq_prio_enc #(.NSRC(NSRC), .VW(VW)) u_enc (
        .pend    (pend),
        .any     (any),
        .top_idx (top_idx),
        .vec     (vec)
    );

    always_comb begin
        logic clr_ovf, clr_tov;
        clr_ovf = vec_acc && any && (top_idx == IW'(SRC_OVF));
        clr_tov = vec_acc && any && (top_idx == IW'(SRC_TOV));

        st_d        = st_q;
        st_d.flags  = flags_nx;
        st_d.unread = unread_nx;
        st_d.ovf    = (st_q.ovf & ~clr_ovf) | ovf_hit;
        st_d.tov    = (st_q.tov & ~clr_tov) | (conv_req & conv_busy);
        if (en_wr) begin
            st_d.en = bus_wdata;
        end

        unique case (bus_sel)
            SEL_FLAGS:  bus_rdata = {2'b00, st_q.flags};
            SEL_ENABLE: bus_rdata = st_q.en;
            SEL_VECTOR: bus_rdata = DW'(vec);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = any;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/conv_irq_vector_chk.sv
module conv_irq_vector_chk
    import conv_irq_pkg::*;
#(
    parameter int  NSLOT = 16,
    localparam int DW    = NSLOT + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSLOT-1:0] slot_set,
    input logic [NSLOT-1:0] res_rd,
    input logic             conv_req,
    input logic             conv_busy,
    input logic [1:0]       bus_sel,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [DW-1:0]    bus_rdata,
    input logic             irq,
    input logic [NSLOT-1:0] flags_q,
    input logic             ovf_q,
    input logic             tov_q,
    input logic [DW-1:0]    en_q
);

    logic vacc;
    assign vacc = (bus_rd | bus_wr) && (bus_sel == SEL_VECTOR);

    // R1: vector is even and within range
    a_r1_vector_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == SEL_VECTOR) |-> (bus_rdata[0] == 1'b0 && bus_rdata <= DW'(2 * (NSLOT + 2))));

    // R9: request matches a non-zero vector
    a_r9_irq_vs_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == SEL_VECTOR) |-> (irq == (bus_rdata != '0)));

    // R3: nothing enabled means no request
    a_r3_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

    // R4: reported overwrite overflow is cleared by the access
    a_r4_ovf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (vacc && bus_rdata == DW'(2) && slot_set == '0) |=> !ovf_q);

    // R4: reported timing overflow is cleared by the access
    a_r4_tov_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (vacc && bus_rdata == DW'(4) && !(conv_req && conv_busy)) |=> !tov_q);

    // R5: vector access leaves slot flags alone
    a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (vacc && slot_set == '0 && res_rd == '0) |=> $stable(flags_q));

    // R6: a set strobe always lands
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_set != '0) |=> ((flags_q & $past(slot_set)) == $past(slot_set)));

    // R8: request while busy raises the timing overflow
    a_r8_tov_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_busy) |=> tov_q);

endmodule

bind conv_irq_vector conv_irq_vector_chk #(.NSLOT(NSLOT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_set  (slot_set),
    .res_rd    (res_rd),
    .conv_req  (conv_req),
    .conv_busy (conv_busy),
    .bus_sel   (bus_sel),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .flags_q   (flags_q),
    .ovf_q     (ovf_q),
    .tov_q     (tov_q),
    .en_q      (en_q)
);

// File: tb/conv_irq_vector_test.sv
module conv_irq_vector_test;

    localparam int  PERIOD = 10;
    localparam int  NSLOT  = 16;
    localparam int  DW     = NSLOT + 2;
    localparam logic [DW-1:0] EN_ALL = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSLOT-1:0] slot_set = '0;
    logic [NSLOT-1:0] res_rd = '0;
    logic             conv_req = 1'b0;
    logic             conv_busy = 1'b0;
    logic [1:0]       bus_sel = 2'd3;
    logic             bus_rd = 1'b0;
    logic             bus_wr = 1'b0;
    logic [DW-1:0]    bus_wdata = '0;
    logic [DW-1:0]    bus_rdata;
    logic             irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    conv_irq_vector #(.NSLOT(NSLOT)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_set  (slot_set),
        .res_rd    (res_rd),
        .conv_req  (conv_req),
        .conv_busy (conv_busy),
        .bus_sel   (bus_sel),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(PERIOD / 2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Read a register without a side effect (no strobe)
    task automatic peek(input logic [1:0] sel, output int val);
        bus_sel = sel;
        #1;
        val = int'(bus_rdata);
        bus_sel = 2'd3;
    endtask

    task automatic vec_is(input string tag, input int exp);
        int v;
        peek(2'd2, v);
        check(tag, v, exp);
        check({tag, " irq"}, int'(irq), int'(exp != 0));
    endtask

    task automatic access(input logic [1:0] sel, input logic rd, input logic wr,
                          input int data, output int val);
        bus_sel = sel; bus_rd = rd; bus_wr = wr; bus_wdata = DW'(data);
        #1;
        val = int'(bus_rdata);
        step();
        bus_rd = 1'b0; bus_wr = 1'b0; bus_sel = 2'd3; bus_wdata = '0;
    endtask

    task automatic set_slots(input int mask);
        slot_set = NSLOT'(mask);
        step();
        slot_set = '0;
    endtask

    task automatic read_slots(input int mask);
        res_rd = NSLOT'(mask);
        step();
        res_rd = '0;
    endtask

    task automatic write_en(input int val);
        int d;
        access(2'd1, 1'b0, 1'b1, val, d);
    endtask

    task automatic t_reset();
        int v;
        vec_is("R1 reset vector", 0);
        peek(2'd0, v); check("R10 reset flags", v, 0);
        peek(2'd1, v); check("R10 reset enables", v, 0);
    endtask

    task automatic t_encoding();
        write_en(int'(EN_ALL));
        set_slots(1 << 0);
        vec_is("R1 slot0 vector", 'h006);
        read_slots(1 << 0);
        set_slots(1 << 15);
        vec_is("R1 slot15 vector", 'h024);
        read_slots(1 << 15);
        vec_is("R1 cleared", 0);
    endtask

    task automatic t_priority();
        set_slots((1 << 3) | (1 << 9));
        vec_is("R2 slot3 over slot9", 'h00C);
        read_slots(1 << 3);
        vec_is("R2 slot9 after slot3", 'h018);
        read_slots(1 << 9);
        vec_is("R2 none", 0);
    endtask

    task automatic t_disabled();
        int v;
        write_en(1 << 5);
        set_slots(1 << 2);
        vec_is("R3 disabled slot2", 0);
        peek(2'd0, v); check("R3 flag2 still visible", v, 1 << 2);
        set_slots(1 << 5);
        vec_is("R3 enabled slot5", 'h010);
        read_slots((1 << 2) | (1 << 5));
        write_en(int'(EN_ALL));
    endtask

    task automatic t_flag_clear();
        int v;
        set_slots(1 << 4);
        access(2'd2, 1'b1, 1'b0, 0, v);
        check("R5 vector read value", v, 'h00E);
        access(2'd2, 1'b0, 1'b1, 0, v);
        peek(2'd0, v); check("R5 flags kept after access", v, 1 << 4);
        vec_is("R5 vector after access", 'h00E);
        read_slots(1 << 4);
        peek(2'd0, v); check("R5 result read clears", v, 0);
        set_slots((1 << 1) | (1 << 6));
        access(2'd0, 1'b0, 1'b1, 1 << 6, v);
        peek(2'd0, v); check("R5 flag write loads", v, 1 << 6);
        access(2'd0, 1'b0, 1'b1, 0, v);
        vec_is("R5 flag write clears", 0);
        read_slots((1 << 1) | (1 << 6));
    endtask

    task automatic t_overflow();
        int v;
        set_slots(1 << 7);
        vec_is("R7 single store no overflow", 'h014);
        set_slots(1 << 7);
        vec_is("R7 repeat store overflow", 'h002);
        access(2'd2, 1'b1, 1'b0, 0, v);
        check("R4 read returns overflow", v, 'h002);
        vec_is("R9 slot7 still pending", 'h014);
        read_slots(1 << 7);
        vec_is("R7 all clear", 0);
        set_slots(1 << 8);
        slot_set = NSLOT'(1 << 8); res_rd = NSLOT'(1 << 8);
        step();
        slot_set = '0; res_rd = '0;
        vec_is("R7 read with set no overflow", 'h016);
        peek(2'd0, v); check("R6 set beats read", v, 1 << 8);
        slot_set = NSLOT'(1 << 8);
        bus_sel = 2'd0; bus_wr = 1'b1; bus_wdata = '0;
        step();
        slot_set = '0; bus_wr = 1'b0; bus_sel = 2'd3;
        peek(2'd0, v); check("R6 set beats flag write", v, 1 << 8);
        vec_is("R7 overflow after unread store", 'h002);
        access(2'd2, 1'b1, 1'b0, 0, v);
        read_slots(1 << 8);
        vec_is("R7 clean", 0);
    endtask

    task automatic t_timing();
        int v;
        conv_req = 1'b1; conv_busy = 1'b0;
        step();
        conv_req = 1'b0;
        vec_is("R8 idle request", 0);
        conv_req = 1'b1; conv_busy = 1'b1;
        step();
        conv_req = 1'b0; conv_busy = 1'b0;
        vec_is("R8 busy request", 'h004);
        set_slots(1 << 2);
        set_slots(1 << 2);
        vec_is("R2 overflow above timing", 'h002);
        access(2'd2, 1'b0, 1'b1, 0, v);
        vec_is("R4 write clears overflow", 'h004);
        access(2'd2, 1'b1, 1'b0, 0, v);
        vec_is("R4 read clears timing", 'h00A);
        read_slots(1 << 2);
        vec_is("R8 clean", 0);
    endtask

    task automatic t_only_top();
        int v;
        write_en(int'(EN_ALL) & ~(1 << NSLOT));
        set_slots(1 << 0);
        set_slots(1 << 0);
        conv_req = 1'b1; conv_busy = 1'b1;
        step();
        conv_req = 1'b0; conv_busy = 1'b0;
        vec_is("R3 disabled overflow hidden", 'h004);
        access(2'd2, 1'b1, 1'b0, 0, v);
        vec_is("R4 timing cleared", 'h006);
        write_en(int'(EN_ALL));
        vec_is("R4 unreported overflow kept", 'h002);
        access(2'd2, 1'b1, 1'b0, 0, v);
        vec_is("R4 overflow then cleared", 'h006);
        read_slots(1 << 0);
    endtask

    task automatic t_regs();
        int v;
        write_en('h25A5A);
        peek(2'd1, v); check("R10 enable readback", v, 'h25A5A);
        peek(2'd3, v); check("R10 unused select", v, 0);
        write_en(0);
        set_slots(1 << 11);
        peek(2'd0, v); check("R10 flags upper zero", v, 1 << 11);
        vec_is("R3 all disabled", 0);
        read_slots(1 << 11);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_encoding();
        t_priority();
        t_disabled();
        t_flag_clear();
        t_overflow();
        t_timing();
        t_only_top();
        t_regs();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule